// File: doc/BRIEF.md
# Converter Serial Result Framer

This block drives the three-wire serial result port of a 12-bit sampling converter. When a conversion-start pulse arrives, it opens a frame by pulling the frame strobe low. It then shifts out a 16-bit word on the serial data line, timed by a serial clock that it derives from the converter clock by dividing by two. The word is four zero bits followed by the conversion result, most significant bit first. A receiver samples data on the falling edges of the serial clock while the strobe is low.

The converter may deliver its result while the frame is already running. A result that arrives during the leading zeros is still sent in the same frame.

A run-time mode input chooses between two kinds of serial clock. One toggles all the time, for receivers that need a continuous clock. The other rests high between frames, so that several converters can share one serial bus. All three lines are open-drain. Each output is an active-low pull enable: 0 pulls the line low and 1 releases it to its pull-up, so an output value equals the line level.

Top module: `conv_serial_framer`

## Requirements
- R1: While reset is asserted, and afterwards until a frame starts, the strobe and data outputs are 1 (released). In gated mode (`sck_free_i`=0) the clock output is also 1.
- R2: A frame carries exactly 16 falling clock edges. The data value at falling edge n (counting from 1) is bit n-1 of the word {4'b0000, result[11:0]}, sent first to last: edges 1 to 4 carry 0 and edge 5 carries result bit 11.
- R3: The strobe output goes to 0 after at most the second rising converter-clock edge following the edge that samples `conv_start_i`=1 while no frame is active. In gated mode it goes to 0 after that edge itself.
- R4: The strobe output stays 0 for exactly 32 converter clocks. It returns to 1 at the serial clock rise that follows the sixteenth falling edge.
- R5: While the strobe stays 0, the data output changes only at the same converter-clock edge where the clock output rises. While the strobe is 1, the data output is 1.
- R6: In gated mode the clock output is 1 whenever no frame is active, and it is 1 when the strobe falls.
- R7: In continuous mode (`sck_free_i`=1) the clock output inverts at every converter-clock edge, inside and outside frames, so the serial clock runs at half the converter clock rate.
- R8: A `conv_start_i` pulse sampled while a frame is active is dropped. No second frame follows the active one.
- R9: `res_vld_i` captures `res_i` at any edge except while result bits are being sent (frame bits 4 to 15). A frame sends the last value captured before its bit 4 begins. With no new capture, the previous result is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start_i | input | 1 | Conversion-start pulse, active high, one clock |
| res_i | input | RES_W (12) | Conversion result |
| res_vld_i | input | 1 | Result capture strobe, active high |
| sck_free_i | input | 1 | 1 = continuous serial clock, 0 = gated serial clock |
| fs_pull_n_o | output | 1 | Frame strobe pull enable, 0 = line low |
| sck_pull_n_o | output | 1 | Serial clock pull enable, 0 = line low |
| sd_pull_n_o | output | 1 | Serial data pull enable, 0 = line low |

## Verification
The assertions assume that `conv_start_i` is a single-clock pulse, and that the mode input changes only while no frame is active. The bench follows both rules: it raises the start for one clock and switches mode only between frames, with at least two idle clocks after each switch. It also places every result capture no later than seven clocks after the start, so each capture lands before bit 4 begins. The only exception is a deliberate late capture that tests whether it is ignored. Mid-frame start pulses are issued inside the strobe-low window, which keeps the ignored-start property checkable at the ports.

// File: rtl/cser_pkg.sv
// Shared types for the converter serial result framer.
// Assumes nothing beyond a single clock domain.
package cser_pkg;
    // Frame sequencer states: idle, waiting for serial clock phase, shifting
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARM   = 2'd1,
        SEQ_SHIFT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/cser_clk_phase.sv
// Serial clock phase generator.
// Produces the serial clock level as a divide-by-two of the converter clock.
// When neither continuous mode nor an active frame asks for toggling, it rests high.
// Assumes: frame_act_i comes from a register in the same domain.
module cser_clk_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic free_run_i,
    input  logic frame_act_i,
    output logic ph_o,
    output logic ph_nxt_o
);
    // Next phase: invert while toggling is requested, otherwise rest high
    always_comb begin
        ph_nxt_o = (free_run_i || frame_act_i) ? ~ph_o : 1'b1;
    end

    // Phase register; reset to the idle (high) level
    always_ff @(posedge clk) begin
        if (!rst_n) ph_o <= 1'b1;
        else        ph_o <= ph_nxt_o;
    end
endmodule

// File: rtl/cser_frame_seq.sv
// Frame sequencer.
// Accepts a start while idle and launches the frame on an edge where the
// serial clock rises (or rests high). It then steps the bit index once per
// serial clock rise and ends at the rise after the final bit.
// Assumes: ph_i/ph_nxt_i come from cser_clk_phase; starts during a frame are dropped.
module cser_frame_seq #(
    parameter int FRAME_W = 16,
    localparam int IDX_W  = $clog2(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ph_i,
    input  logic             ph_nxt_i,
    output logic             active_o,
    output logic [IDX_W-1:0] idx_o
);
    import cser_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    seq_state_e       state_q;
    logic [IDX_W-1:0] idx_q;

    // State and bit index update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        idx_q   <= '0;
                        state_q <= ph_nxt_i ? SEQ_SHIFT : SEQ_ARM;
                    end
                end
                SEQ_ARM: begin
                    if (ph_nxt_i) begin
                        idx_q   <= '0;
                        state_q <= SEQ_SHIFT;
                    end
                end
                SEQ_SHIFT: begin
                    if (!ph_i) begin
                        if (idx_q == LAST_IDX) state_q <= SEQ_IDLE;
                        else                   idx_q   <= idx_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Outputs taken straight from state
    always_comb begin
        active_o = (state_q == SEQ_SHIFT);
        idx_o    = idx_q;
    end
endmodule

// File: rtl/cser_bit_drive.sv
// Result holder and open-drain line driver.
// Holds the latest result; captures are blocked while result bits are on the line.
// Selects the current frame bit and forms the active-low pull enables.
// Assumes: idx_i counts frame bits from 0, header first.
module cser_bit_drive #(
    parameter int RES_W   = 12,
    parameter int HDR_W   = 4,
    localparam int FRAME_W = RES_W + HDR_W,
    localparam int IDX_W   = $clog2(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] res_i,
    input  logic             res_vld_i,
    input  logic             active_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             ph_i,
    output logic             fs_pull_n_o,
    output logic             sck_pull_n_o,
    output logic             sd_pull_n_o
);
    logic [RES_W-1:0]   res_q;
    logic [FRAME_W-1:0] word;
    logic [IDX_W-1:0]   pos;
    logic               in_result;

    // Result bits are on the line from header end to frame end
    always_comb begin
        in_result = active_i && (idx_i >= IDX_W'(HDR_W));
    end

    // Result capture, frozen while result bits are being sent
    always_ff @(posedge clk) begin
        if (!rst_n)                      res_q <= '0;
        else if (res_vld_i && !in_result) res_q <= res_i;
    end

    // Frame word and current bit position, first bit at the top
    always_comb begin
        word = {{HDR_W{1'b0}}, res_q};
        pos  = IDX_W'(FRAME_W - 1) - idx_i;
    end

    // Open-drain pull enables: 0 pulls the line low, 1 releases it
    always_comb begin
        fs_pull_n_o  = ~active_i;
        sck_pull_n_o = ph_i;
        sd_pull_n_o  = active_i ? word[pos] : 1'b1;
    end
endmodule

// File: rtl/conv_serial_framer.sv
// Converter serial result framer, top level.
// Sends {HDR_W zeros, RES_W-bit result} framed by an active-low strobe, on a
// serial clock at half the converter clock rate, continuous or gated.
// Assumes: conv_start_i is a one-clock pulse; sck_free_i changes only between frames.
module conv_serial_framer #(
    parameter int RES_W = 12,
    parameter int HDR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start_i,
    input  logic [RES_W-1:0] res_i,
    input  logic             res_vld_i,
    input  logic             sck_free_i,
    output logic             fs_pull_n_o,
    output logic             sck_pull_n_o,
    output logic             sd_pull_n_o
);
    localparam int FRAME_W = RES_W + HDR_W;
    localparam int IDX_W   = $clog2(FRAME_W);

    logic             ph;
    logic             ph_nxt;
    logic             active;
    logic [IDX_W-1:0] idx;

    cser_clk_phase u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .free_run_i  (sck_free_i),
        .frame_act_i (active),
        .ph_o        (ph),
        .ph_nxt_o    (ph_nxt)
    );

    cser_frame_seq #(.FRAME_W(FRAME_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (conv_start_i),
        .ph_i     (ph),
        .ph_nxt_i (ph_nxt),
        .active_o (active),
        .idx_o    (idx)
    );

    cser_bit_drive #(.RES_W(RES_W), .HDR_W(HDR_W)) u_drive (
        .clk          (clk),
        .rst_n        (rst_n),
        .res_i        (res_i),
        .res_vld_i    (res_vld_i),
        .active_i     (active),
        .idx_i        (idx),
        .ph_i         (ph),
        .fs_pull_n_o  (fs_pull_n_o),
        .sck_pull_n_o (sck_pull_n_o),
        .sd_pull_n_o  (sd_pull_n_o)
    );
endmodule

// File: rtl/cser_checker.sv
// Port-level property checker for conv_serial_framer, attached by bind.
// Assumes: conv_start_i is a one-clock pulse; mode changes only between frames.
module cser_checker #(
    parameter int RES_W = 12,
    parameter int HDR_W = 4
) (
    input logic clk,
    input logic rst_n,
    input logic conv_start_i,
    input logic sck_free_i,
    input logic fs_pull_n_o,
    input logic sck_pull_n_o,
    input logic sd_pull_n_o
);
    localparam int LOW_CYC = 2 * (RES_W + HDR_W);
    localparam int CNT_W   = $clog2(LOW_CYC + 2) + 1;

    logic [2:0]       lat_q;
    logic [CNT_W-1:0] low_q;
    logic             up_q;

    // Count clocks from an accepted start until the strobe falls
    always_ff @(posedge clk) begin
        if (!rst_n)                                         lat_q <= '0;
        else if (fs_pull_n_o && (conv_start_i || lat_q != 0)) lat_q <= lat_q + {2'b0, (lat_q != 3'd7)};
        else                                                lat_q <= '0;
    end

    // Count clocks the strobe stays low
    always_ff @(posedge clk) begin
        if (!rst_n)            low_q <= '0;
        else if (!fs_pull_n_o) low_q <= low_q + {{(CNT_W-1){1'b0}}, (low_q != {CNT_W{1'b1}})};
        else                   low_q <= '0;
    end

    // Marks the cycles after the first clock out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) up_q <= 1'b0;
        else        up_q <= 1'b1;
    end

    a_r3_strobe_latency: assert property (@(posedge clk) disable iff (!rst_n)
        lat_q <= 3'd2);

    a_r4_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_pull_n_o) |-> (low_q == CNT_W'(LOW_CYC)));

    a_r5_data_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs_pull_n_o && $past(!fs_pull_n_o) && !$stable(sd_pull_n_o)) |-> $rose(sck_pull_n_o));

    a_r5_data_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fs_pull_n_o |-> sd_pull_n_o);

    a_r6_gated_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_free_i && $past(!sck_free_i) && fs_pull_n_o && $past(fs_pull_n_o)) |-> sck_pull_n_o);

    a_r7_free_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && sck_free_i && $past(sck_free_i)) |-> (sck_pull_n_o != $past(sck_pull_n_o)));
endmodule

bind conv_serial_framer cser_checker #(.RES_W(RES_W), .HDR_W(HDR_W)) u_cser_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_start_i (conv_start_i),
    .sck_free_i   (sck_free_i),
    .fs_pull_n_o  (fs_pull_n_o),
    .sck_pull_n_o (sck_pull_n_o),
    .sd_pull_n_o  (sd_pull_n_o)
);

// File: tb/tb_conv_serial_framer.sv
// Self-checking bench for conv_serial_framer: random and directed frames.
module tb_conv_serial_framer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        conv_start_i;
    logic [11:0] res_i;
    logic        res_vld_i;
    logic        sck_free_i;
    logic        fs_pull_n_o;
    logic        sck_pull_n_o;
    logic        sd_pull_n_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [11:0] exp_res = 12'h000;

    conv_serial_framer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_start_i (conv_start_i),
        .res_i        (res_i),
        .res_vld_i    (res_vld_i),
        .sck_free_i   (sck_free_i),
        .fs_pull_n_o  (fs_pull_n_o),
        .sck_pull_n_o (sck_pull_n_o),
        .sd_pull_n_o  (sd_pull_n_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [11:0] r);
        return {4'b0000, r};
    endfunction

    // One frame: k = capture delay in clocks after start (-1: no capture)
    task automatic run_frame(input bit free, input logic [11:0] val, input int k, input bit junk);
        @(negedge clk);
        sck_free_i = free;
        repeat (2) @(negedge clk);
        conv_start_i = 1'b1;
        res_i        = val;
        res_vld_i    = (k == 0);
        if (k >= 0) exp_res = val;
        fork
            begin
                for (int c = 1; c <= 24; c++) begin
                    @(negedge clk);
                    conv_start_i = junk && (c == 12);
                    res_vld_i    = (c == k) || (junk && c == 20);
                    res_i        = (c == 20) ? ~val : val;
                end
                res_vld_i = 1'b0;
            end
            begin
                int lat = 0;
                int low = 0;
                int nfall = 0;
                int stray = 0;
                logic [15:0] w = '0;
                logic ps;
                logic pd;
                do begin
                    @(negedge clk);
                    lat++;
                end while (fs_pull_n_o && lat < 10);
                if (free) chk(lat >= 1 && lat <= 2, "R3 latency free", lat, 2);
                else      chk(lat == 1, "R3 latency gated", lat, 1);
                if (!free) chk(sck_pull_n_o == 1'b1, "R6 clock high at strobe fall", sck_pull_n_o, 1);
                ps = sck_pull_n_o;
                pd = sd_pull_n_o;
                low = 1;
                while (low < 80) begin
                    @(negedge clk);
                    if (fs_pull_n_o) break;
                    low++;
                    if (ps && !sck_pull_n_o) begin
                        w = {w[14:0], sd_pull_n_o};
                        nfall++;
                    end
                    if (sd_pull_n_o != pd && !(!ps && sck_pull_n_o)) stray++;
                    ps = sck_pull_n_o;
                    pd = sd_pull_n_o;
                end
                chk(low == 32, "R4 strobe width", low, 32);
                chk(nfall == 16, "R2 falling edges", nfall, 16);
                chk(w == exp_word(exp_res), "R2 R9 frame word", w, exp_word(exp_res));
                chk(stray == 0, "R5 data changes only at rise", stray, 0);
                chk(sd_pull_n_o == 1'b1, "R5 data released after frame", sd_pull_n_o, 1);
            end
        join
        // Idle window: no new frame (R8), clock behaviour per mode (R6/R7)
        begin
            logic prev = sck_pull_n_o;
            int extra = 0;
            int bad = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (!fs_pull_n_o) extra++;
                if (free && sck_pull_n_o == prev) bad++;
                if (!free && !sck_pull_n_o) bad++;
                prev = sck_pull_n_o;
            end
            if (junk) chk(extra == 0, "R8 mid-frame start dropped", extra, 0);
            else      chk(extra == 0, "R4 strobe stays high after frame", extra, 0);
            if (free) chk(bad == 0, "R7 clock toggles while idle", bad, 0);
            else      chk(bad == 0, "R6 clock rests high while idle", bad, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst_n = 1'b0;
        conv_start_i = 1'b0;
        res_i = '0;
        res_vld_i = 1'b0;
        sck_free_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(fs_pull_n_o == 1'b1, "R1 strobe in reset", fs_pull_n_o, 1);
        chk(sd_pull_n_o == 1'b1, "R1 data in reset", sd_pull_n_o, 1);
        chk(sck_pull_n_o == 1'b1, "R1 clock in reset", sck_pull_n_o, 1);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(fs_pull_n_o && sd_pull_n_o && sck_pull_n_o, "R1 lines released after reset",
            {fs_pull_n_o, sd_pull_n_o, sck_pull_n_o}, 7);

        // Directed corners
        run_frame(1'b0, 12'hA5C, 0, 1'b0);
        run_frame(1'b1, 12'h3C1, 7, 1'b0);
        run_frame(1'b1, 12'h000, -1, 1'b0);  // R9: previous result repeated
        run_frame(1'b0, 12'hFFF, 3, 1'b1);   // R8/R9: mid-frame start and late capture
        run_frame(1'b1, 12'h800, 5, 1'b1);
        run_frame(1'b0, 12'h001, 1, 1'b0);
        run_frame(1'b0, 12'h000, 2, 1'b0);
        run_frame(1'b1, 12'h7FF, 6, 1'b0);

        // Constrained random frames
        for (int f = 0; f < 24; f++) begin
            bit free = 1'($urandom_range(1, 0));
            int k = int'($urandom_range(8, 0)) - 1;
            bit junk = 1'($urandom_range(1, 0));
            logic [11:0] v = 12'($urandom);
            repeat ($urandom_range(3, 0)) @(negedge clk);
            run_frame(free, v, k, junk);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule